// File: doc/BRIEF.md
# Fused Multiply-Add Path Selection and Alignment Control

This block is the exponent-processing front of a dual-path fused multiply-add unit. It takes the biased exponents of the addend A and the two factors B and C, an operation select, an effective-subtract flag and a flag that reports that the significand product overflowed into an extra integer bit. From these it forms the exponent difference between the addend and the product. For a plain addition the product is C alone. It then decides whether the near path or the far path of the datapath takes the operation.

For the near path it produces the small right shift applied to the inverted addend. For the far path it produces the alignment distance, which operand is the one that gets shifted, a flag that marks a distance beyond the useful width, and how many +1 injections are needed to finish the two's complement of the inverted operand. The shifters, adders and normalizer that consume these controls sit outside the block.

The results can be taken straight from the logic or from an output register, which is chosen by a parameter.

Top module: `fma_path_ctl`

## Requirements
- R1: With `is_fma`=1, `exp_diff` is the two's-complement value exp_a − (exp_b + exp_c − BIAS), `EW`+2 bits wide, and `diff_neg` is 1 exactly when that value is negative.
- R2: With `is_fma`=0, `exp_diff` is exp_a − exp_c. In this mode `exp_b` and `prod_ovf` have no effect on any output.
- R3: With `is_fma`=1, `use_close` is 1 only when `eff_sub`=1 and one of these holds: d is 0 or 1; d is 2 and `prod_ovf`=1; d is −1 and `prod_ovf`=0. In every other case `use_close` is 0.
- R4: With `is_fma`=0, `use_close` is 1 exactly when `eff_sub`=1 and −1 ≤ d ≤ 1.
- R5: When `use_close`=1, `close_shift` equals 2 − d. This value lies in 0..3, and for additions it lies in 1..3. When `use_close`=0, `close_shift` is 0.
- R6: When `use_close`=0, `far_a_shift` is 1 when d < 0 (the addend is shifted) and 0 otherwise (the product side is shifted), and `far_shift` is |d|, limited as set out in R7. When `use_close`=1, `far_shift` and `far_a_shift` are both 0.
- R7: The cap on the far shift is 2·MW when the addend is shifted in a multiply-add, and MW in every other case. When |d| is above the cap, `far_shift` equals the cap and `far_sat` is 1. When |d| is at or below the cap, `far_sat` is 0.
- R8: `cpl_ones` is the count of +1 injections. It is 0 on the near path and for effective additions. For a far-path effective subtraction it is 1 when the addend is shifted (and so inverted), 2 when the product side is shifted in a multiply-add, and 1 when C is shifted in an addition.
- R9: With REG_OUT=1, every output shows the result for the inputs present at the previous rising clock edge, and an active-low `rst_n` clears every output to 0. With REG_OUT=0, the outputs follow the inputs within the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the optional output register |
| rst_n | input | 1 | Asynchronous active-low reset of the output register |
| exp_a | input | EW | Biased exponent of the addend |
| exp_b | input | EW | Biased exponent of the first factor |
| exp_c | input | EW | Biased exponent of the second factor |
| is_fma | input | 1 | 1 for multiply-add, 0 for plain addition |
| eff_sub | input | 1 | Effective subtraction after sign resolution |
| prod_ovf | input | 1 | Significand product overflowed by one bit |
| exp_diff | output | EW+2 | Signed exponent difference d |
| diff_neg | output | 1 | Sign of d |
| use_close | output | 1 | 1 selects the near path, 0 the far path |
| close_shift | output | 3 | Near-path right shift of the inverted addend |
| far_shift | output | clog2(2·MW+1) | Far-path alignment distance after capping |
| far_a_shift | output | 1 | 1 when the addend is the operand shifted on the far path |
| far_sat | output | 1 | Distance exceeded its cap; only the sticky bit is affected |
| cpl_ones | output | 2 | Number of +1 injections for the far-path complement |

## Verification
The bench builds two copies of the block, both with the double-precision defaults (EW=11, BIAS=1023, MW=53). One copy has REG_OUT=1 and the other has REG_OUT=0, and both are driven by the same stimulus. The registered copy is checked one edge after each input change, and the combinational copy is checked within the cycle. At one moment both are sampled while the register still holds the previous result, which shows the one-cycle delay directly. With 11-bit exponents the bench can reach both ends of the difference range (+3070 and −3071). It can also place d exactly on and one past the 53 and 106 caps, and on every overflow-dependent boundary of the near-path test.

// File: rtl/fpc_pkg.sv
package fpc_pkg;
   localparam int CLOSE_SHIFT_W = 3;

   typedef enum logic [1:0] {
      CPL_NONE = 2'd0,
      CPL_ONE  = 2'd1,
      CPL_TWO  = 2'd2
   } cpl_e;
endpackage

// File: rtl/fpc_expdiff.sv
module fpc_expdiff #(
   parameter int EW   = 11,
   parameter int BIAS = 1023,
   parameter int DW   = EW + 2
) (
   input  logic [EW-1:0]        exp_a,
   input  logic [EW-1:0]        exp_b,
   input  logic [EW-1:0]        exp_c,
   input  logic                 is_fma,
   output logic signed [DW-1:0] diff,
   output logic                 neg
);
   localparam logic signed [DW-1:0] BIAS_S = DW'(BIAS);

   logic signed [DW-1:0] ea_s, eb_s, ec_s, prod_s;

   always_comb begin
      ea_s   = $signed({2'b00, exp_a});
      eb_s   = $signed({2'b00, exp_b});
      ec_s   = $signed({2'b00, exp_c});
      // product exponent keeps a single bias; add mode bypasses the factor B
      prod_s = is_fma ? (eb_s + ec_s - BIAS_S) : ec_s;
      diff   = ea_s - prod_s;
      neg    = diff[DW-1];
   end
endmodule

// File: rtl/fpc_pathsel.sv
module fpc_pathsel #(
   parameter int DW = 13
) (
   input  logic signed [DW-1:0]                     diff,
   input  logic                                     is_fma,
   input  logic                                     eff_sub,
   input  logic                                     prod_ovf,
   output logic                                     use_close,
   output logic [fpc_pkg::CLOSE_SHIFT_W-1:0]        close_shift
);
   localparam int CSW = fpc_pkg::CLOSE_SHIFT_W;
   localparam logic signed [DW-1:0] D_M1 = '1;
   localparam logic signed [DW-1:0] D_Z  = '0;
   localparam logic signed [DW-1:0] D_P1 = DW'(1);
   localparam logic signed [DW-1:0] D_P2 = DW'(2);

   logic ovf_eff;
   logic hit;

   always_comb begin
      // a plain add never produces a product overflow
      ovf_eff   = is_fma & prod_ovf;
      hit       = (diff == D_Z) || (diff == D_P1) ||
                  ((diff == D_P2) && ovf_eff) ||
                  ((diff == D_M1) && !ovf_eff);
      use_close = eff_sub & hit;
      close_shift = use_close ? CSW'(D_P2 - diff) : '0;
   end
endmodule

// File: rtl/fpc_farctl.sv
module fpc_farctl #(
   parameter int DW = 13,
   parameter int MW = 53,
   parameter int SW = 7
) (
   input  logic signed [DW-1:0] diff,
   input  logic                 neg,
   input  logic                 is_fma,
   input  logic                 eff_sub,
   input  logic                 use_close,
   output logic [SW-1:0]        far_shift,
   output logic                 far_a_shift,
   output logic                 far_sat,
   output fpc_pkg::cpl_e        cpl
);
   import fpc_pkg::*;

   localparam int ACAP = 2 * MW;

   logic [DW-1:0] mag;
   logic [DW-1:0] cap;
   logic          over;

   always_comb begin
      mag  = neg ? DW'(-diff) : DW'(diff);
      cap  = (neg && is_fma) ? DW'(ACAP) : DW'(MW);
      over = mag > cap;

      far_a_shift = !use_close && neg;
      far_sat     = !use_close && over;
      if (use_close)   far_shift = '0;
      else if (over)   far_shift = SW'(cap);
      else             far_shift = SW'(mag);

      // the shifted (smaller) operand is the one inverted
      if (use_close || !eff_sub) cpl = CPL_NONE;
      else if (neg)              cpl = CPL_ONE;
      else if (is_fma)           cpl = CPL_TWO;
      else                       cpl = CPL_ONE;
   end
endmodule

// File: rtl/fma_path_ctl.sv
module fma_path_ctl #(
   parameter int EW      = 11,
   parameter int BIAS    = 1023,
   parameter int MW      = 53,
   parameter bit REG_OUT = 1'b1,
   localparam int DW     = EW + 2,
   localparam int SW     = $clog2(2 * MW + 1)
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [EW-1:0]        exp_a,
   input  logic [EW-1:0]        exp_b,
   input  logic [EW-1:0]        exp_c,
   input  logic                 is_fma,
   input  logic                 eff_sub,
   input  logic                 prod_ovf,
   output logic signed [DW-1:0] exp_diff,
   output logic                 diff_neg,
   output logic                 use_close,
   output logic [2:0]           close_shift,
   output logic [SW-1:0]        far_shift,
   output logic                 far_a_shift,
   output logic                 far_sat,
   output logic [1:0]           cpl_ones
);
   import fpc_pkg::*;

   if (EW < 4) begin : g_bad_ew
      $error("fma_path_ctl: EW must be at least 4");
   end
   if (BIAS != (1 << (EW - 1)) - 1) begin : g_bad_bias
      $error("fma_path_ctl: BIAS must equal 2**(EW-1)-1");
   end
   if (MW < 4) begin : g_bad_mw
      $error("fma_path_ctl: MW must be at least 4");
   end
   if (CLOSE_SHIFT_W != 3) begin : g_bad_csw
      $error("fma_path_ctl: near-path shift field must be 3 bits");
   end

   logic signed [DW-1:0] diff_c;
   logic                 neg_c, close_c, fa_c, sat_c;
   logic [2:0]           cs_c;
   logic [SW-1:0]        fs_c;
   cpl_e                 cpl_c;

   fpc_expdiff #(.EW(EW), .BIAS(BIAS), .DW(DW)) u_diff (
      .exp_a(exp_a), .exp_b(exp_b), .exp_c(exp_c), .is_fma(is_fma),
      .diff(diff_c), .neg(neg_c)
   );

   fpc_pathsel #(.DW(DW)) u_sel (
      .diff(diff_c), .is_fma(is_fma), .eff_sub(eff_sub), .prod_ovf(prod_ovf),
      .use_close(close_c), .close_shift(cs_c)
   );

   fpc_farctl #(.DW(DW), .MW(MW), .SW(SW)) u_far (
      .diff(diff_c), .neg(neg_c), .is_fma(is_fma), .eff_sub(eff_sub),
      .use_close(close_c), .far_shift(fs_c), .far_a_shift(fa_c),
      .far_sat(sat_c), .cpl(cpl_c)
   );

   if (REG_OUT) begin : g_reg
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            exp_diff    <= '0;
            diff_neg    <= 1'b0;
            use_close   <= 1'b0;
            close_shift <= '0;
            far_shift   <= '0;
            far_a_shift <= 1'b0;
            far_sat     <= 1'b0;
            cpl_ones    <= '0;
         end else begin
            exp_diff    <= diff_c;
            diff_neg    <= neg_c;
            use_close   <= close_c;
            close_shift <= cs_c;
            far_shift   <= fs_c;
            far_a_shift <= fa_c;
            far_sat     <= sat_c;
            cpl_ones    <= cpl_c;
         end
      end
   end else begin : g_comb
      always_comb begin
         exp_diff    = diff_c;
         diff_neg    = neg_c;
         use_close   = close_c;
         close_shift = cs_c;
         far_shift   = fs_c;
         far_a_shift = fa_c;
         far_sat     = sat_c;
         cpl_ones    = cpl_c;
      end
   end
endmodule

// File: rtl/fpc_checker.sv
module fpc_checker #(
   parameter bit REG_OUT = 1'b1,
   parameter int MW      = 53,
   parameter int SW      = 7
) (
   input logic          clk,
   input logic          rst_n,
   input logic          is_fma,
   input logic          eff_sub,
   input logic          diff_neg,
   input logic          use_close,
   input logic [2:0]    close_shift,
   input logic [SW-1:0] far_shift,
   input logic          far_a_shift,
   input logic          far_sat,
   input logic [1:0]    cpl_ones
);
   localparam logic [SW-1:0] CAP_P = SW'(MW);
   localparam logic [SW-1:0] CAP_A = SW'(2 * MW);

   logic fma_d, sub_d;

   if (REG_OUT) begin : g_dly
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            fma_d <= 1'b0;
            sub_d <= 1'b0;
         end else begin
            fma_d <= is_fma;
            sub_d <= eff_sub;
         end
      end
   end else begin : g_now
      assign fma_d = is_fma;
      assign sub_d = eff_sub;
   end

   AST_CLOSE_NEEDS_SUB: assert property (@(posedge clk) disable iff (!rst_n)
      use_close |-> sub_d);                                             // R3
   AST_ADD_CLOSE_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (use_close && !fma_d) |-> (close_shift != 3'd0));                 // R5
   AST_CLOSE_SHIFT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      !use_close |-> (close_shift == 3'd0));                            // R5
   AST_FAR_IDLE_IN_CLOSE: assert property (@(posedge clk) disable iff (!rst_n)
      use_close |-> (far_shift == '0 && !far_sat && !far_a_shift && cpl_ones == 2'd0)); // R6
   AST_A_SHIFT_NEG: assert property (@(posedge clk) disable iff (!rst_n)
      far_a_shift |-> diff_neg);                                        // R6
   AST_SAT_AT_CAP: assert property (@(posedge clk) disable iff (!rst_n)
      far_sat |-> (far_shift == ((far_a_shift && fma_d) ? CAP_A : CAP_P))); // R7
   AST_TWO_ONES_FMA: assert property (@(posedge clk) disable iff (!rst_n)
      (cpl_ones == 2'd2) |-> (fma_d && sub_d && !far_a_shift));         // R8
   AST_CPL_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
      cpl_ones != 2'd3);                                                // R8
endmodule

bind fma_path_ctl fpc_checker #(.REG_OUT(REG_OUT), .MW(MW), .SW(SW)) u_chk (
   .clk(clk), .rst_n(rst_n), .is_fma(is_fma), .eff_sub(eff_sub),
   .diff_neg(diff_neg), .use_close(use_close), .close_shift(close_shift),
   .far_shift(far_shift), .far_a_shift(far_a_shift), .far_sat(far_sat),
   .cpl_ones(cpl_ones)
);

// File: tb/fma_path_ctl_tb.sv
module fma_path_ctl_tb;
   localparam int EW = 11;
   localparam int DW = EW + 2;
   localparam int SW = 7;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic [EW-1:0] exp_a = '0, exp_b = '0, exp_c = '0;
   logic is_fma = 1'b0, eff_sub = 1'b0, prod_ovf = 1'b0;

   logic signed [DW-1:0] r_diff, c_diff;
   logic r_neg, c_neg, r_close, c_close, r_fa, c_fa, r_sat, c_sat;
   logic [2:0] r_cs, c_cs;
   logic [SW-1:0] r_fs, c_fs;
   logic [1:0] r_cpl, c_cpl;

   int n_chk = 0;
   int n_bad = 0;
   bit done = 1'b0;

   always #5 clk = ~clk;

   fma_path_ctl #(.REG_OUT(1'b1)) u_dut (
      .clk(clk), .rst_n(rst_n), .exp_a(exp_a), .exp_b(exp_b), .exp_c(exp_c),
      .is_fma(is_fma), .eff_sub(eff_sub), .prod_ovf(prod_ovf),
      .exp_diff(r_diff), .diff_neg(r_neg), .use_close(r_close),
      .close_shift(r_cs), .far_shift(r_fs), .far_a_shift(r_fa),
      .far_sat(r_sat), .cpl_ones(r_cpl)
   );

   fma_path_ctl #(.REG_OUT(1'b0)) u_dut_comb (
      .clk(clk), .rst_n(rst_n), .exp_a(exp_a), .exp_b(exp_b), .exp_c(exp_c),
      .is_fma(is_fma), .eff_sub(eff_sub), .prod_ovf(prod_ovf),
      .exp_diff(c_diff), .diff_neg(c_neg), .use_close(c_close),
      .close_shift(c_cs), .far_shift(c_fs), .far_a_shift(c_fa),
      .far_sat(c_sat), .cpl_ones(c_cpl)
   );

   task automatic chk(input string req, input string what, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   // expected outputs derived from the requirement text
   task automatic expect_all(input string tag, input int ea, input int eb, input int ec,
                             input bit fma, input bit sub, input bit ovf, input bit regd);
      int d, mag, cap, cs, fs, cp;
      bit ov, cl, neg, sat, fa;
      d   = fma ? ea - (eb + ec - 1023) : ea - ec;
      ov  = fma & ovf;
      cl  = sub && (d == 0 || d == 1 || (d == 2 && ov) || (d == -1 && !ov));
      cs  = cl ? 2 - d : 0;
      neg = d < 0;
      mag = neg ? -d : d;
      cap = (neg && fma) ? 106 : 53;
      sat = !cl && mag > cap;
      fs  = cl ? 0 : (mag > cap ? cap : mag);
      fa  = !cl && neg;
      cp  = (cl || !sub) ? 0 : (neg ? 1 : (fma ? 2 : 1));
      if (regd) begin
         chk(fma ? "R1" : "R2", {tag, " diff"}, int'(r_diff), d);
         chk("R1", {tag, " neg"}, int'(r_neg), int'(neg));
         chk(fma ? "R3" : "R4", {tag, " close"}, int'(r_close), int'(cl));
         chk("R5", {tag, " close_shift"}, int'(r_cs), cs);
         chk("R6", {tag, " far_shift"}, int'(r_fs), fs);
         chk("R6", {tag, " far_a"}, int'(r_fa), int'(fa));
         chk("R7", {tag, " sat"}, int'(r_sat), int'(sat));
         chk("R8", {tag, " cpl"}, int'(r_cpl), cp);
      end else begin
         chk(fma ? "R1" : "R2", {tag, " comb diff"}, int'(c_diff), d);
         chk(fma ? "R3" : "R4", {tag, " comb close"}, int'(c_close), int'(cl));
         chk("R5", {tag, " comb close_shift"}, int'(c_cs), cs);
         chk("R6", {tag, " comb far_shift"}, int'(c_fs), fs);
         chk("R7", {tag, " comb sat"}, int'(c_sat), int'(sat));
         chk("R8", {tag, " comb cpl"}, int'(c_cpl), cp);
      end
   endtask

   task automatic apply(input int ea, input int eb, input int ec,
                        input bit fma, input bit sub, input bit ovf);
      exp_a = EW'(ea); exp_b = EW'(eb); exp_c = EW'(ec);
      is_fma = fma; eff_sub = sub; prod_ovf = ovf;
   endtask

   task automatic run_case(input string tag, input int ea, input int eb, input int ec,
                           input bit fma, input bit sub, input bit ovf);
      @(negedge clk);
      apply(ea, eb, ec, fma, sub, ovf);
      #1 expect_all(tag, ea, eb, ec, fma, sub, ovf, 1'b0);
      @(negedge clk);
      expect_all(tag, ea, eb, ec, fma, sub, ovf, 1'b1);
   endtask

   task automatic t_reset();
      @(negedge clk);
      chk("R9", "reset diff", int'(r_diff), 0);
      chk("R9", "reset close", int'(r_close), 0);
      chk("R9", "reset far_shift", int'(r_fs), 0);
      chk("R9", "reset cpl", int'(r_cpl), 0);
   endtask

   task automatic t_fma_near();
      run_case("fma d=0 sub", 1028, 1023, 1028, 1, 1, 0);
      run_case("fma d=1 sub", 1029, 1023, 1028, 1, 1, 1);
      run_case("fma d=2 ovf", 1030, 1023, 1028, 1, 1, 1);
      run_case("fma d=2 no ovf", 1030, 1023, 1028, 1, 1, 0);
      run_case("fma d=-1 no ovf", 1027, 1023, 1028, 1, 1, 0);
      run_case("fma d=-1 ovf", 1027, 1023, 1028, 1, 1, 1);
      run_case("fma d=0 add", 1028, 1023, 1028, 1, 0, 0);
      run_case("fma d=3 sub", 1031, 1023, 1028, 1, 1, 1);
   endtask

   task automatic t_add();
      run_case("add d=-1", 1000, 0, 1001, 0, 1, 0);
      run_case("add d=-1 b/ovf ignored", 1000, 2047, 1001, 0, 1, 1);
      run_case("add d=1", 1002, 5, 1001, 0, 1, 0);
      run_case("add d=2", 1003, 0, 1001, 0, 1, 1);
      run_case("add d=-2", 999, 0, 1001, 0, 1, 0);
      run_case("add d=5 eff add", 1006, 0, 1001, 0, 0, 0);
   endtask

   task automatic t_caps();
      run_case("fma d=-106", 917, 1023, 1023, 1, 1, 0);
      run_case("fma d=-107", 916, 1023, 1023, 1, 1, 0);
      run_case("fma d=53", 1076, 1023, 1023, 1, 1, 0);
      run_case("fma d=54", 1077, 1023, 1023, 1, 0, 0);
      run_case("add d=-53", 1000, 0, 1053, 0, 1, 0);
      run_case("add d=-54", 1000, 0, 1054, 0, 1, 0);
   endtask

   task automatic t_extremes();
      run_case("fma max d", 2047, 0, 0, 1, 1, 0);
      run_case("fma min d", 0, 2047, 2047, 1, 1, 1);
      run_case("add min d", 0, 0, 2047, 0, 0, 0);
   endtask

   task automatic t_latency();
      @(negedge clk);
      apply(1028, 1023, 1028, 1, 1, 0);
      @(negedge clk);
      apply(1100, 1023, 1028, 1, 1, 0);
      #1;
      chk("R9", "reg holds previous close", int'(r_close), 1);
      chk("R9", "comb shows new close", int'(c_close), 0);
      chk("R9", "comb shows new far_shift", int'(c_fs), 53);
      @(negedge clk);
      chk("R9", "reg catches up far_shift", int'(r_fs), 53);
   endtask

   initial begin
      t_reset();
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
      t_fma_near();
      t_add();
      t_caps();
      t_extremes();
      t_latency();
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end

   initial begin
      #200000;
      if (!done) begin
         n_chk++;
         n_bad++;
         $display("FAIL R9 watchdog actual=running expected=finished");
         $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
         $finish;
      end
   end
endmodule